// File: doc/BRIEF.md
# Machine-Check Reaction Controller

This block decides what a processor core does after one of its error detectors reports a machine-check event. Software picks one of five reaction policies on a mode input. From that policy, the error class and the current sequence state, the controller issues requests to the instruction-retry unit, the maintenance-store logger, the low-storage logger and the interrupt logic. It also drives a damage-class code, a stopped flag and a sticky check-stop flag. Each request is a request/acknowledge handshake, and the units that serve the requests live outside the block.

The controller also holds the machine-check interrupt-class enable mask. Reset, system reset and IPL return the mask to its defined start-up value. A write port replaces the whole mask, and a PSW-load strobe sets the PSW-derived mask bit. The check-stop enable bit in that mask decides whether a check-stop can ever be entered.

Modes: 0 normal, 1 hard-stop, 2 no-retry, 3 disable, 4 stop-after-log (5 to 7 act as normal). Error classes: 0 retryable, 1 unretryable, 2 clocking (3 acts as unretryable). Damage codes: 0 none, 1 instruction-processing damage, 2 system damage. All outputs are registered.

Top module: `mchk_ctrl`

## Requirements
- R1: After reset, every request is low, the damage code is 0, the stopped, check-stop and pending flags are low, and the mask reads 8'h03. In the mask, bit 0 is external damage (on), bit 1 is check-stop enable (on), bits 2..6 are the recovery, interval-timer, timing, degradation and channel-status enables (off), and bit 7 is the PSW-derived mask bit (off).
- R2: In normal mode, a retryable error raises the retry request. Its acknowledge raises the maintenance-store log request. That acknowledge returns the controller to idle, with no interrupt.
- R3: In normal mode, an unretryable error raises requests in this order: maintenance-store log, then low-storage log, then interrupt with damage code 2. After the interrupt acknowledge, the controller is idle.
- R4: In normal mode with check-stop enabled, a clocking error raises the maintenance-store log request. Its acknowledge enters check-stop, with stopped high and no low-storage log.
- R5: In normal mode with check-stop enabled, an unretryable or clocking error that arrives while a sequence is in progress abandons the current request. The controller then raises the maintenance-store log request and enters check-stop after that log's acknowledge.
- R6: In check-stop, the start and restart inputs have no effect. Only system reset or IPL leaves the state, and either one also restores the mask to 8'h03.
- R7: With mask bit 1 clear, check-stop is never entered. A clocking error follows the unretryable sequence of R3, and a second error during a sequence is ignored.
- R8: In hard-stop mode, any error at once sets stopped and pending, with no request. A later start or restart clears both flags and then replays the maintenance-store log, the low-storage log and the interrupt, in that order. The damage code is 1 for a retryable error and 2 otherwise.
- R9: In no-retry mode, an error raises the maintenance-store log request and never the retry request. The log acknowledge raises the interrupt, with damage code 1 for a retryable error and 2 otherwise.
- R10: In disable mode, an error of any class raises no request and no interrupt, and sets neither the stopped flag nor the check-stop flag.
- R11: In stop-after-log mode, any error raises retry first and then the maintenance-store log. The log acknowledge sets stopped, not check-stop. A start clears stopped.
- R12: The mode input is sampled only when the controller is idle. A change during a sequence takes effect for the next error.
- R13: Every request stays high until its acknowledge arrives (or until it is abandoned under R5), and at most one request is high at a time.
- R14: A mask write replaces the whole mask. A PSW load sets bit 7 to the supplied value. System reset and IPL restore the mask to 8'h03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Reaction policy selector |
| err_valid_i | input | 1 | One-cycle error event strobe |
| err_cls_i | input | 2 | Error class of the event |
| start_i | input | 1 | Start key |
| restart_i | input | 1 | Restart function |
| sys_reset_i | input | 1 | System reset |
| ipl_i | input | 1 | Initial program load |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wd_i | input | 8 | Mask write data |
| psw_ld_i | input | 1 | PSW load strobe |
| psw_bit_i | input | 1 | PSW-derived mask bit value |
| retry_ack_i | input | 1 | Retry done |
| mslog_ack_i | input | 1 | Maintenance-store log done |
| stlog_ack_i | input | 1 | Low-storage log done |
| irq_ack_i | input | 1 | Interrupt taken |
| retry_req_o | output | 1 | Retry request |
| mslog_req_o | output | 1 | Maintenance-store log request |
| stlog_req_o | output | 1 | Low-storage log request |
| irq_req_o | output | 1 | Machine-check interrupt request |
| dmg_code_o | output | 2 | Damage class, valid with the interrupt |
| stopped_o | output | 1 | Processor stopped |
| chkstop_o | output | 1 | Check-stop state |
| pend_o | output | 1 | Deferred log pending |
| mask_o | output | 8 | Interrupt-class enable mask |

## Verification
On every cycle, the assertions check that at most one request is high and that requests hold until their acknowledge. They also check that check-stop implies stopped and persists until system reset or IPL, that the damage code appears only with an interrupt, that pending implies stopped, and that reset events restore the mask. The ordering of each policy's request sequence, the hard-stop replay, the mode sampling at idle, the second-error escalation and the effect of clearing the check-stop enable can only be shown by the bench's scenarios.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int MODE_W = 3;
  localparam int CLS_W  = 2;
  localparam int DMG_W  = 2;

  localparam logic [MODE_W-1:0] M_NORMAL  = 3'd0;
  localparam logic [MODE_W-1:0] M_HARD    = 3'd1;
  localparam logic [MODE_W-1:0] M_NORETRY = 3'd2;
  localparam logic [MODE_W-1:0] M_DISABLE = 3'd3;
  localparam logic [MODE_W-1:0] M_STOPLOG = 3'd4;

  localparam logic [CLS_W-1:0] C_RETRY = 2'd0;
  localparam logic [CLS_W-1:0] C_UNRET = 2'd1;
  localparam logic [CLS_W-1:0] C_CLOCK = 2'd2;

  localparam logic [DMG_W-1:0] D_NONE = 2'd0;
  localparam logic [DMG_W-1:0] D_IPD  = 2'd1;
  localparam logic [DMG_W-1:0] D_SD   = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RETRY, S_MSLOG, S_STLOG, S_IRQ,
    S_STOP, S_HSTOP, S_CSLOG, S_CHK
  } st_e;

  function automatic logic [MODE_W-1:0] legal_mode(input logic [MODE_W-1:0] m);
    return (m > M_STOPLOG) ? M_NORMAL : m;
  endfunction

  function automatic logic [DMG_W-1:0] dmg_of(input logic [CLS_W-1:0] c);
    return (c == C_RETRY) ? D_IPD : D_SD;
  endfunction
endpackage

// File: rtl/mchk_mask.sv
module mchk_mask #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = 'h3,
  parameter int            PSW_BIT = W-1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  input  logic         psw_ld_i,
  input  logic         psw_bit_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      mask_q <= RST_VAL;
    end else if (wr_i) begin
      mask_q <= wd_i;
    end else if (psw_ld_i) begin
      mask_q[PSW_BIT] <= psw_bit_i;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/mchk_fsm.sv
module mchk_fsm
  import mchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              err_valid_i,
  input  logic [CLS_W-1:0]  err_cls_i,
  input  logic              go_i,
  input  logic              clr_i,
  input  logic              cse_i,
  input  logic              retry_ack_i,
  input  logic              mslog_ack_i,
  input  logic              stlog_ack_i,
  input  logic              irq_ack_i,
  output st_e               state_d,
  output logic [CLS_W-1:0]  cls_d
);
  st_e               state_q;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CLS_W-1:0]  cls_q;
  logic              busy_q, busy_d;
  logic              esc;
  st_e               after_ms;

  // a further non-retryable error during a normal-mode sequence escalates
  assign esc = busy_q && (mode_q == M_NORMAL) && cse_i &&
               err_valid_i && (err_cls_i != C_RETRY);

  always_comb begin
    unique case (mode_q)
      M_NORMAL:  after_ms = (cls_q == C_RETRY) ? S_IDLE : S_STLOG;
      M_HARD:    after_ms = S_STLOG;
      M_NORETRY: after_ms = S_IRQ;
      M_STOPLOG: after_ms = S_STOP;
      default:   after_ms = S_IDLE;
    endcase
  end

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cls_d   = cls_q;
    busy_d  = busy_q;
    if (clr_i) begin
      state_d = S_IDLE;
      busy_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (err_valid_i) begin
            mode_d = legal_mode(mode_i);
            cls_d  = err_cls_i;
            unique case (legal_mode(mode_i))
              M_NORMAL: begin
                busy_d = 1'b1;
                if (err_cls_i == C_CLOCK && cse_i) state_d = S_CSLOG;
                else if (err_cls_i == C_RETRY)    state_d = S_RETRY;
                else                              state_d = S_MSLOG;
              end
              M_HARD:    state_d = S_HSTOP;
              M_NORETRY: begin state_d = S_MSLOG; busy_d = 1'b1; end
              M_STOPLOG: begin state_d = S_RETRY; busy_d = 1'b1; end
              default:   state_d = S_IDLE;
            endcase
          end
        end
        S_RETRY: begin
          if (esc)              state_d = S_CSLOG;
          else if (retry_ack_i) state_d = S_MSLOG;
        end
        S_MSLOG: begin
          if (esc) state_d = S_CSLOG;
          else if (mslog_ack_i) begin
            state_d = after_ms;
            if (after_ms == S_IDLE || after_ms == S_STOP) busy_d = 1'b0;
          end
        end
        S_STLOG: begin
          if (esc)              state_d = S_CSLOG;
          else if (stlog_ack_i) state_d = S_IRQ;
        end
        S_IRQ: begin
          if (esc) state_d = S_CSLOG;
          else if (irq_ack_i) begin
            state_d = S_IDLE;
            busy_d  = 1'b0;
          end
        end
        S_STOP:  if (go_i) state_d = S_IDLE;
        S_HSTOP: if (go_i) begin state_d = S_MSLOG; busy_d = 1'b1; end
        S_CSLOG: if (mslog_ack_i) begin state_d = S_CHK; busy_d = 1'b0; end
        S_CHK:   state_d = S_CHK;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mode_q  <= M_NORMAL;
      cls_q   <= C_RETRY;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cls_q   <= cls_d;
      busy_q  <= busy_d;
    end
  end
endmodule

// File: rtl/mchk_outreg.sv
module mchk_outreg
  import mchk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  st_e              state_d,
  input  logic [CLS_W-1:0] cls_d,
  output logic             retry_req_o,
  output logic             mslog_req_o,
  output logic             stlog_req_o,
  output logic             irq_req_o,
  output logic [DMG_W-1:0] dmg_code_o,
  output logic             stopped_o,
  output logic             chkstop_o,
  output logic             pend_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      retry_req_o <= 1'b0;
      mslog_req_o <= 1'b0;
      stlog_req_o <= 1'b0;
      irq_req_o   <= 1'b0;
      dmg_code_o  <= D_NONE;
      stopped_o   <= 1'b0;
      chkstop_o   <= 1'b0;
      pend_o      <= 1'b0;
    end else begin
      retry_req_o <= (state_d == S_RETRY);
      mslog_req_o <= (state_d == S_MSLOG) || (state_d == S_CSLOG);
      stlog_req_o <= (state_d == S_STLOG);
      irq_req_o   <= (state_d == S_IRQ);
      dmg_code_o  <= (state_d == S_IRQ) ? dmg_of(cls_d) : D_NONE;
      stopped_o   <= (state_d == S_STOP) || (state_d == S_HSTOP) || (state_d == S_CHK);
      chkstop_o   <= (state_d == S_CHK);
      pend_o      <= (state_d == S_HSTOP);
    end
  end
endmodule

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
  import mchk_pkg::*;
#(
  parameter int                MASK_W   = 8,
  parameter logic [MASK_W-1:0] MASK_RST = 'h3,
  parameter int                CSE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              err_valid_i,
  input  logic [CLS_W-1:0]  err_cls_i,
  input  logic              start_i,
  input  logic              restart_i,
  input  logic              sys_reset_i,
  input  logic              ipl_i,
  input  logic              mask_wr_i,
  input  logic [MASK_W-1:0] mask_wd_i,
  input  logic              psw_ld_i,
  input  logic              psw_bit_i,
  input  logic              retry_ack_i,
  input  logic              mslog_ack_i,
  input  logic              stlog_ack_i,
  input  logic              irq_ack_i,
  output logic              retry_req_o,
  output logic              mslog_req_o,
  output logic              stlog_req_o,
  output logic              irq_req_o,
  output logic [DMG_W-1:0]  dmg_code_o,
  output logic              stopped_o,
  output logic              chkstop_o,
  output logic              pend_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam int PSW_BIT = MASK_W - 1;

  logic             clr;
  logic             go;
  st_e              state_d;
  logic [CLS_W-1:0] cls_d;

  assign clr = sys_reset_i || ipl_i;
  assign go  = start_i || restart_i;

  mchk_mask #(.W(MASK_W), .RST_VAL(MASK_RST), .PSW_BIT(PSW_BIT)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .wr_i      (mask_wr_i),
    .wd_i      (mask_wd_i),
    .psw_ld_i  (psw_ld_i),
    .psw_bit_i (psw_bit_i),
    .mask_o    (mask_o)
  );

  mchk_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .err_valid_i (err_valid_i),
    .err_cls_i   (err_cls_i),
    .go_i        (go),
    .clr_i       (clr),
    .cse_i       (mask_o[CSE_BIT]),
    .retry_ack_i (retry_ack_i),
    .mslog_ack_i (mslog_ack_i),
    .stlog_ack_i (stlog_ack_i),
    .irq_ack_i   (irq_ack_i),
    .state_d     (state_d),
    .cls_d       (cls_d)
  );

  mchk_outreg u_out (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .cls_d       (cls_d),
    .retry_req_o (retry_req_o),
    .mslog_req_o (mslog_req_o),
    .stlog_req_o (stlog_req_o),
    .irq_req_o   (irq_req_o),
    .dmg_code_o  (dmg_code_o),
    .stopped_o   (stopped_o),
    .chkstop_o   (chkstop_o),
    .pend_o      (pend_o)
  );
endmodule

// File: rtl/mchk_ctrl_chk.sv
module mchk_ctrl_chk
  import mchk_pkg::*;
#(
  parameter int                MASK_W   = 8,
  parameter logic [MASK_W-1:0] MASK_RST = 'h3
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_reset_i,
  input logic              ipl_i,
  input logic              retry_ack_i,
  input logic              mslog_ack_i,
  input logic              stlog_ack_i,
  input logic              irq_ack_i,
  input logic              retry_req_o,
  input logic              mslog_req_o,
  input logic              stlog_req_o,
  input logic              irq_req_o,
  input logic [DMG_W-1:0]  dmg_code_o,
  input logic              stopped_o,
  input logic              chkstop_o,
  input logic              pend_o,
  input logic [MASK_W-1:0] mask_o
);
  logic clr;
  assign clr = sys_reset_i || ipl_i;

  a_r13_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({retry_req_o, mslog_req_o, stlog_req_o, irq_req_o}));

  a_r13_mslog_held: assert property (@(posedge clk) disable iff (rst)
    (mslog_req_o && !mslog_ack_i && !clr) |=> mslog_req_o);

  a_r13_stlog_held: assert property (@(posedge clk) disable iff (rst)
    (stlog_req_o && !stlog_ack_i && !clr) |=> (stlog_req_o || mslog_req_o));

  a_r13_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && !irq_ack_i && !clr) |=> (irq_req_o || mslog_req_o));

  a_r6_chkstop_sticky: assert property (@(posedge clk) disable iff (rst)
    (chkstop_o && !clr) |=> chkstop_o);

  a_r6_chkstop_stopped: assert property (@(posedge clk) disable iff (rst)
    chkstop_o |-> stopped_o);

  a_r8_pend_stopped: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> (stopped_o && !chkstop_o));

  a_r3_dmg_with_irq: assert property (@(posedge clk) disable iff (rst)
    (dmg_code_o != D_NONE) |-> irq_req_o);

  a_r14_clear_restores: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mask_o == MASK_RST && !stopped_o && !chkstop_o));
endmodule

bind mchk_ctrl mchk_ctrl_chk #(.MASK_W(MASK_W), .MASK_RST(MASK_RST)) u_chk (.*);

// File: tb/tb_mchk_ctrl.sv
module tb_mchk_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic       err_valid_i = 1'b0;
  logic [1:0] err_cls_i = 2'd0;
  logic       start_i = 1'b0, restart_i = 1'b0, sys_reset_i = 1'b0, ipl_i = 1'b0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_wd_i = 8'h00;
  logic       psw_ld_i = 1'b0, psw_bit_i = 1'b0;
  logic       retry_ack_i = 1'b0, mslog_ack_i = 1'b0, stlog_ack_i = 1'b0, irq_ack_i = 1'b0;
  logic       retry_req_o, mslog_req_o, stlog_req_o, irq_req_o;
  logic [1:0] dmg_code_o;
  logic       stopped_o, chkstop_o, pend_o;
  logic [7:0] mask_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mchk_ctrl dut (.*);

  // {mode[2:0], cls[1:0], {retry,mslog,stlog,irq}, stopped}
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    {3'd0, 2'd0, 4'b1000, 1'b0},
    {3'd0, 2'd1, 4'b0100, 1'b0},
    {3'd0, 2'd2, 4'b0100, 1'b0},
    {3'd1, 2'd1, 4'b0000, 1'b1},
    {3'd2, 2'd0, 4'b0100, 1'b0},
    {3'd2, 2'd1, 4'b0100, 1'b0},
    {3'd3, 2'd2, 4'b0000, 1'b0},
    {3'd4, 2'd0, 4'b1000, 1'b0},
    {3'd4, 2'd1, 4'b1000, 1'b0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  // snapshot: {retry,mslog,stlog,irq, stopped,chkstop,pend, dmg[1:0]}
  task automatic expect_st(input string tag, input logic [3:0] req,
                           input logic stp, input logic cs, input logic pd,
                           input logic [1:0] dmg);
    logic [8:0] act, exp;
    act = {retry_req_o, mslog_req_o, stlog_req_o, irq_req_o, stopped_o, chkstop_o, pend_o, dmg_code_o};
    exp = {req, stp, cs, pd, dmg};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  task automatic expect_mask(input string tag, input logic [7:0] exp);
    checks++;
    if (mask_o !== exp) begin
      fails++;
      $display("FAIL %s: mask actual %02h expected %02h", tag, mask_o, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; step();
  endtask

  task automatic err(input logic [1:0] c);
    err_valid_i = 1'b1; err_cls_i = c; step(); err_valid_i = 1'b0;
  endtask

  task automatic ack_retry(); retry_ack_i = 1'b1; step(); retry_ack_i = 1'b0; endtask
  task automatic ack_ms();    mslog_ack_i = 1'b1; step(); mslog_ack_i = 1'b0; endtask
  task automatic ack_st();    stlog_ack_i = 1'b1; step(); stlog_ack_i = 1'b0; endtask
  task automatic ack_irq();   irq_ack_i   = 1'b1; step(); irq_ack_i   = 1'b0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    expect_st("R1 reset outputs", 4'b0000, 0, 0, 0, 2'd0);
    expect_mask("R1 reset mask", 8'h03);

    // table: first reaction of each policy to an error
    for (int i = 0; i < NV; i++) begin
      do_reset();
      mode_i = VEC[i][9:7];
      err(VEC[i][6:5]);
      expect_st($sformatf("R2/R8/R9/R10/R11 vec%0d", i), VEC[i][4:1], VEC[i][0], 0, VEC[i][9:7] == 3'd1, 2'd0);
    end

    // R2 normal retryable, with R13 hold check
    do_reset(); mode_i = 3'd0;
    err(2'd0); step(); step();
    expect_st("R13 retry held", 4'b1000, 0, 0, 0, 2'd0);
    ack_retry(); expect_st("R2 log after retry", 4'b0100, 0, 0, 0, 2'd0);
    ack_ms();    expect_st("R2 idle", 4'b0000, 0, 0, 0, 2'd0);

    // R3 normal unretryable
    err(2'd1);
    ack_ms();  expect_st("R3 stlog", 4'b0010, 0, 0, 0, 2'd0);
    ack_st();  expect_st("R3 irq sd", 4'b0001, 0, 0, 0, 2'd2);
    ack_irq(); expect_st("R3 idle", 4'b0000, 0, 0, 0, 2'd0);

    // R4 clocking check-stop, R6 sticky
    err(2'd2); expect_st("R4 cs log", 4'b0100, 0, 0, 0, 2'd0);
    ack_ms();  expect_st("R4 chkstop", 4'b0000, 1, 1, 0, 2'd0);
    start_i = 1'b1; step(); start_i = 1'b0;
    expect_st("R6 start ignored", 4'b0000, 1, 1, 0, 2'd0);
    restart_i = 1'b1; step(); restart_i = 1'b0;
    expect_st("R6 restart ignored", 4'b0000, 1, 1, 0, 2'd0);
    ipl_i = 1'b1; step(); ipl_i = 1'b0;
    expect_st("R6 ipl leaves", 4'b0000, 0, 0, 0, 2'd0);

    // R5 second unretryable escalates
    err(2'd1); ack_ms();
    expect_st("R5 first seq stlog", 4'b0010, 0, 0, 0, 2'd0);
    err(2'd1); expect_st("R5 abandon to log", 4'b0100, 0, 0, 0, 2'd0);
    ack_ms();  expect_st("R5 chkstop", 4'b0000, 1, 1, 0, 2'd0);
    sys_reset_i = 1'b1; step(); sys_reset_i = 1'b0;
    expect_st("R6 sysreset leaves", 4'b0000, 0, 0, 0, 2'd0);

    // R7 check-stop enable cleared
    mask_wr_i = 1'b1; mask_wd_i = 8'h01; step(); mask_wr_i = 1'b0;
    expect_mask("R14 mask write", 8'h01);
    err(2'd2); expect_st("R7 clock as unret", 4'b0100, 0, 0, 0, 2'd0);
    err(2'd1);
    ack_ms();  expect_st("R7 no escalation", 4'b0010, 0, 0, 0, 2'd0);
    ack_st();  expect_st("R7 irq", 4'b0001, 0, 0, 0, 2'd2);
    ack_irq(); expect_st("R7 idle", 4'b0000, 0, 0, 0, 2'd0);

    // R8 hard-stop deferred replay
    do_reset(); mode_i = 3'd1;
    err(2'd0); step();
    expect_st("R8 stopped pending", 4'b0000, 1, 0, 1, 2'd0);
    start_i = 1'b1; step(); start_i = 1'b0;
    expect_st("R8 replay mslog", 4'b0100, 0, 0, 0, 2'd0);
    ack_ms();  expect_st("R8 replay stlog", 4'b0010, 0, 0, 0, 2'd0);
    ack_st();  expect_st("R8 replay irq ipd", 4'b0001, 0, 0, 0, 2'd1);
    ack_irq(); expect_st("R8 idle", 4'b0000, 0, 0, 0, 2'd0);

    // R9 no-retry
    mode_i = 3'd2;
    err(2'd0); ack_ms();
    expect_st("R9 irq ipd", 4'b0001, 0, 0, 0, 2'd1);
    ack_irq();
    err(2'd1); ack_ms();
    expect_st("R9 irq sd", 4'b0001, 0, 0, 0, 2'd2);
    ack_irq();

    // R10 disable
    mode_i = 3'd3;
    err(2'd2); step(); step();
    expect_st("R10 no reaction", 4'b0000, 0, 0, 0, 2'd0);

    // R11 stop-after-log
    mode_i = 3'd4;
    err(2'd1); ack_retry();
    expect_st("R11 log", 4'b0100, 0, 0, 0, 2'd0);
    ack_ms(); expect_st("R11 stopped", 4'b0000, 1, 0, 0, 2'd0);
    start_i = 1'b1; step(); start_i = 1'b0;
    expect_st("R11 start resumes", 4'b0000, 0, 0, 0, 2'd0);

    // R12 mode change mid-sequence
    mode_i = 3'd0;
    err(2'd1); mode_i = 3'd3;
    ack_ms();  expect_st("R12 old mode kept", 4'b0010, 0, 0, 0, 2'd0);
    ack_st(); ack_irq();
    err(2'd2); expect_st("R12 new mode at idle", 4'b0000, 0, 0, 0, 2'd0);

    // R14 mask handling
    psw_ld_i = 1'b1; psw_bit_i = 1'b1; step(); psw_ld_i = 1'b0;
    expect_mask("R14 psw load", 8'h83);
    ipl_i = 1'b1; step(); ipl_i = 1'b0;
    expect_mask("R14 ipl restores", 8'h03);
    mask_wr_i = 1'b1; mask_wd_i = 8'hFF; step(); mask_wr_i = 1'b0;
    expect_mask("R14 write all", 8'hFF);
    sys_reset_i = 1'b1; step(); sys_reset_i = 1'b0;
    expect_mask("R14 sysreset restores", 8'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule